// File: doc/BRIEF.md
# Audio Transmitter Control and Status Registers

This block is the register front end of a serial digital audio transmitter. Software reaches it over a simple word-addressed register bus. It holds a run bit, an interrupt-enable bit and a sample-format bit in a control register. A status register carries a sticky FIFO error flag and a read-only conversion-active indication. Each register answers at four word addresses: one plain read/write address and three alias addresses, which set, clear or invert only the bits written as one.

Conversion is not started by the run bit on its own. Setting run arms a start gate, and the gate opens only once the external sample FIFO reports a fill level at or above a threshold. The threshold is 4 words for 16-bit samples and 8 words for 32-bit samples. Once open, the gate stays open until run is cleared. FIFO overflow and underflow pulses that arrive while the transmitter is running latch the error flag. The interrupt line follows the error flag gated by the enable bit, so it stays high until software clears the flag through the clear alias.

Top module: `audtx_csr`

## Requirements
- R1: After a synchronous active-high reset, every register bit is zero, and `irq`, `conv_active` and `bus_rdata` are zero.
- R2: A plain write to the control register (byte offset 0x00) loads bits [2:0]: run in bit 0, interrupt enable in bit 1, and format in bit 2 (0 = 16-bit, 1 = 32-bit). Bits above bit 2 are ignored and read as zero.
- R3: On either register, a write to offset +0x4 sets, +0x8 clears and +0xC inverts exactly the bits written as one. Bits written as zero keep their value.
- R4: When run is one, a pulse on `fifo_ovf` or `fifo_unf` sets the error flag (status offset 0x10, bit 0) on that clock edge. When run is zero, such pulses are ignored.
- R5: The error flag is cleared only by writing a one to bit 0 of the status clear alias (0x18). Plain writes (0x10) and toggle writes (0x1C) leave it unchanged, and a write to the set alias (0x14) sets it. If a FIFO event arrives in the same cycle as a clear, the flag stays set.
- R6: `irq` is high exactly when the error flag and interrupt enable are both one. It changes on the same clock edge as the register bits it depends on.
- R7: With run one and format 16-bit, `conv_active` rises on the first clock edge at which `fifo_level` is at least 4. It stays low below 4.
- R8: With run one and format 32-bit, `conv_active` rises only when `fifo_level` is at least 8. Once risen, it stays high whatever the fill level does.
- R9: Clearing run drops `conv_active` on the same edge. A later set of run waits for the threshold again.
- R10: Status bit 1 reads the conversion-active state. Writes through any status address leave it unchanged.
- R11: `bus_rdata` is registered: a read request is answered on the next clock edge. Any alias address returns its register's value, and addresses at or above 0x20 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| fifo_level | input | LVL_W | Words currently held in the sample FIFO |
| fifo_ovf | input | 1 | FIFO overflow pulse |
| fifo_unf | input | 1 | FIFO underflow pulse |
| irq | output | 1 | Interrupt request |
| conv_active | output | 1 | Conversion running |

## Verification
The alias decode is exercised with all-ones, single-bit and mixed write patterns on both registers. These patterns distinguish set, clear and toggle behaviour from a plain write, and they show that zero bits are preserved. The error flag is driven by overflow and by underflow, with run both on and off. Clear attempts go through every status alias, which separates the one legal clear path from the rest, and one clear attempt lands in the same cycle as a FIFO event. The start gate is swept across fill levels just below and at each format's threshold, then the level is dropped after start and run is toggled. This separates a threshold that is too low or too high from a gate that fails to latch or to re-arm.

// File: rtl/audtx_csr_pkg.sv
package audtx_csr_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_WRITE,
    OP_SET,
    OP_CLR,
    OP_TOG
  } reg_op_e;

  localparam int CTRL_RUN = 0;
  localparam int CTRL_IE  = 1;
  localparam int CTRL_FMT = 2;
  localparam int CTRL_W   = 3;

  function automatic reg_op_e alias_op(input logic [1:0] sel);
    case (sel)
      2'd0:    return OP_WRITE;
      2'd1:    return OP_SET;
      2'd2:    return OP_CLR;
      default: return OP_TOG;
    endcase
  endfunction

endpackage

// File: rtl/audtx_csr_bitop.sv
module audtx_csr_bitop
  import audtx_csr_pkg::*;
#(
  parameter int W = 3,
  parameter logic [W-1:0] ALLOW_WR  = '1,
  parameter logic [W-1:0] ALLOW_SET = '1,
  parameter logic [W-1:0] ALLOW_CLR = '1,
  parameter logic [W-1:0] ALLOW_TOG = '1
) (
  input  logic [W-1:0] old_i,
  input  logic [W-1:0] wdata_i,
  input  reg_op_e      op_i,
  output logic [W-1:0] nxt_o
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_comb begin
      nxt_o[b] = old_i[b];
      unique case (op_i)
        OP_WRITE: if (ALLOW_WR[b])                nxt_o[b] = wdata_i[b];
        OP_SET:   if (ALLOW_SET[b] && wdata_i[b]) nxt_o[b] = 1'b1;
        OP_CLR:   if (ALLOW_CLR[b] && wdata_i[b]) nxt_o[b] = 1'b0;
        OP_TOG:   if (ALLOW_TOG[b] && wdata_i[b]) nxt_o[b] = ~old_i[b];
        default:  nxt_o[b] = old_i[b];
      endcase
    end
  end

endmodule

// File: rtl/audtx_csr_gate.sv
module audtx_csr_gate #(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [LVL_W-1:0] thr_i,
  input  logic [LVL_W-1:0] level_i,
  output logic             active_o
);

  always_ff @(posedge clk) begin
    if (rst) active_o <= 1'b0;
    else     active_o <= run_i & (active_o | (level_i >= thr_i));
  end

  // R7 / R8: start only after the level reached the threshold
  a_r7_start_needs_level: assert property (@(posedge clk) disable iff (rst)
    $rose(active_o) |-> $past(level_i >= thr_i));

  // R9: gate cannot stay open without run
  a_r9_run_low_closes: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> !active_o);

endmodule

// File: rtl/audtx_csr.sv
module audtx_csr
  import audtx_csr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int LVL_W     = 5,
  parameter int TH_NARROW = 4,
  parameter int TH_WIDE   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic              fifo_ovf,
  input  logic              fifo_unf,
  output logic              irq,
  output logic              conv_active
);

  localparam logic [LVL_W-1:0] THR_N = LVL_W'(TH_NARROW);
  localparam logic [LVL_W-1:0] THR_W = LVL_W'(TH_WIDE);
  localparam logic [ADDR_W-1:0] CLR_STAT = ADDR_W'(8'h18);

  logic [CTRL_W-1:0] ctrl_q, ctrl_nx;
  logic              err_q, err_sw, err_nx;
  logic              in_map, wr_ctrl, wr_stat, rd_req;
  reg_op_e           op_dec, op_ctrl, op_stat;
  logic [LVL_W-1:0]  thr_nx;

  assign in_map  = (bus_addr[ADDR_W-1:5] == '0);
  assign op_dec  = alias_op(bus_addr[3:2]);
  assign wr_ctrl = bus_sel & bus_wr & in_map & ~bus_addr[4];
  assign wr_stat = bus_sel & bus_wr & in_map &  bus_addr[4];
  assign rd_req  = bus_sel & ~bus_wr;
  assign op_ctrl = wr_ctrl ? op_dec : OP_NONE;
  assign op_stat = wr_stat ? op_dec : OP_NONE;

  audtx_csr_bitop #(.W(CTRL_W)) u_ctrl_op (
    .old_i   (ctrl_q),
    .wdata_i (bus_wdata[CTRL_W-1:0]),
    .op_i    (op_ctrl),
    .nxt_o   (ctrl_nx)
  );

  audtx_csr_bitop #(
    .W(1), .ALLOW_WR(1'b0), .ALLOW_SET(1'b1), .ALLOW_CLR(1'b1), .ALLOW_TOG(1'b0)
  ) u_err_op (
    .old_i   (err_q),
    .wdata_i (bus_wdata[0]),
    .op_i    (op_stat),
    .nxt_o   (err_sw)
  );

  assign err_nx = err_sw | (ctrl_q[CTRL_RUN] & (fifo_ovf | fifo_unf));
  assign thr_nx = ctrl_nx[CTRL_FMT] ? THR_W : THR_N;

  audtx_csr_gate #(.LVL_W(LVL_W)) u_gate (
    .clk      (clk),
    .rst      (rst),
    .run_i    (ctrl_nx[CTRL_RUN]),
    .thr_i    (thr_nx),
    .level_i  (fifo_level),
    .active_o (conv_active)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      err_q     <= 1'b0;
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      ctrl_q <= ctrl_nx;
      err_q  <= err_nx;
      irq    <= err_nx & ctrl_nx[CTRL_IE];
      if (rd_req) begin
        if (!in_map)          bus_rdata <= '0;
        else if (bus_addr[4]) bus_rdata <= DATA_W'({conv_active, err_q});
        else                  bus_rdata <= DATA_W'(ctrl_q);
      end
    end
  end

  // R4: an event while running latches the flag
  a_r4_event_sets_err: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[CTRL_RUN] && (fifo_ovf || fifo_unf)) |=> err_q);

  // R5: the flag only falls after a clear-alias write of bit 0
  a_r5_err_clear_path: assert property (@(posedge clk) disable iff (rst)
    $fell(err_q) |-> $past(bus_sel && bus_wr && bus_addr == CLR_STAT && bus_wdata[0]));

  // R6: interrupt needs the enable bit
  a_r6_irq_needs_ie: assert property (@(posedge clk) disable iff (rst)
    irq |-> ctrl_q[CTRL_IE]);

  // R6: interrupt needs the flag
  a_r6_irq_needs_err: assert property (@(posedge clk) disable iff (rst)
    irq |-> err_q);

  // R9: active only with run set
  a_r9_active_needs_run: assert property (@(posedge clk) disable iff (rst)
    conv_active |-> ctrl_q[CTRL_RUN]);

endmodule

// File: tb/audtx_csr_tb.sv
module audtx_csr_tb;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int LVL_W  = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_sel = 1'b0, bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic [LVL_W-1:0]  fifo_level = '0;
  logic              fifo_ovf = 1'b0, fifo_unf = 1'b0;
  logic              irq, conv_active;

  int checks = 0, fails = 0;
  bit done = 0;
  bit rd_seen = 0;
  logic [DATA_W-1:0] exp_q[$];
  string             tag_q[$];

  always #4ns clk = ~clk;

  audtx_csr u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fifo_level(fifo_level), .fifo_ovf(fifo_ovf), .fifo_unf(fifo_unf),
    .irq(irq), .conv_active(conv_active)
  );

  // monitor: a read seen at an edge is compared at the following falling edge
  always @(posedge clk) rd_seen <= bus_sel && !bus_wr && !rst;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [DATA_W-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        fails++;
        $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e, input string tag);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic pulse(input bit ovf, input bit unf);
    @(negedge clk);
    fifo_ovf = ovf; fifo_unf = unf;
    @(negedge clk);
    fifo_ovf = 0; fifo_unf = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(8ns * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 irq", irq, 0);
    chk("R1 active", conv_active, 0);
    chk("R1 rdata", |bus_rdata, 0);
    rd(8'h00, 32'h0, "R1 ctrl");
    rd(8'h10, 32'h0, "R1 stat");

    // R2 plain write, reserved bits dropped
    wr(8'h00, 32'hFFFF_FFFF);
    chk("R2 active below thr", conv_active, 0);
    rd(8'h00, 32'h7, "R2 ctrl all ones");
    wr(8'h00, 32'h0);
    rd(8'h00, 32'h0, "R2 ctrl zero");

    // R3 aliases
    wr(8'h04, 32'h6);
    rd(8'h00, 32'h6, "R3 set");
    wr(8'h08, 32'h4);
    rd(8'h00, 32'h2, "R3 clear");
    wr(8'h0C, 32'h5);
    rd(8'h00, 32'h7, "R3 toggle");
    wr(8'h08, 32'h7);

    // R4 ignored while run is zero
    pulse(1, 0);
    rd(8'h10, 32'h0, "R4 no run");

    // run + ie, 16-bit format, FIFO empty
    wr(8'h00, 32'h3);
    chk("R7 below thr", conv_active, 0);
    pulse(1, 0);
    chk("R6 irq on ovf", irq, 1);
    rd(8'h10, 32'h1, "R4 ovf sets err");

    // R5 clear paths
    wr(8'h10, 32'h0);
    wr(8'h1C, 32'h1);
    rd(8'h10, 32'h1, "R5 plain/toggle keep err");
    chk("R6 irq held", irq, 1);
    wr(8'h08, 32'h2);
    chk("R6 irq off with ie=0", irq, 0);
    wr(8'h18, 32'h1);
    rd(8'h10, 32'h0, "R5 clear alias");
    wr(8'h04, 32'h2);
    pulse(0, 1);
    chk("R4 unf sets irq", irq, 1);
    // clear colliding with event
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 8'h18; bus_wdata = 32'h1; fifo_ovf = 1;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; fifo_ovf = 0;
    rd(8'h10, 32'h1, "R5 event wins over clear");
    wr(8'h18, 32'h1);
    chk("R6 irq after clear", irq, 0);

    // R7 16-bit threshold
    fifo_level = 3;
    @(negedge clk);
    chk("R7 level 3", conv_active, 0);
    fifo_level = 4;
    @(negedge clk);
    chk("R7 level 4", conv_active, 1);
    rd(8'h10, 32'h2, "R10 active reads");
    fifo_level = 0;
    @(negedge clk);
    chk("R8 hold after drain", conv_active, 1);
    wr(8'h10, 32'h0);
    wr(8'h1C, 32'h2);
    rd(8'h10, 32'h2, "R10 writes ignored");

    // R9 stop and re-arm
    wr(8'h08, 32'h1);
    chk("R9 stop", conv_active, 0);
    wr(8'h04, 32'h1);
    chk("R9 rearm waits", conv_active, 0);

    // R8 32-bit threshold
    wr(8'h00, 32'h5);
    fifo_level = 4;
    @(negedge clk);
    chk("R8 level 4", conv_active, 0);
    fifo_level = 7;
    @(negedge clk);
    chk("R8 level 7", conv_active, 0);
    fifo_level = 8;
    @(negedge clk);
    chk("R8 level 8", conv_active, 1);

    // R5 set alias, R11 alias read and unmapped
    wr(8'h14, 32'h1);
    chk("R6 no irq ie=0", irq, 0);
    rd(8'h10, 32'h3, "R5 set alias");
    rd(8'h0C, 32'h5, "R11 alias read");
    rd(8'h20, 32'h0, "R11 unmapped");
    rd(8'h18, 32'h3, "R11 status alias read");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule